// File: doc/BRIEF.md
# VGA Planar Memory Write Datapath

This block turns CPU byte writes aimed at the legacy 128 KiB graphics aperture into updates of a four-plane video memory. Each memory word is 32 bits wide and holds one byte per plane. Plane p sits in bits 8p+7:8p. The block decodes the aperture offset and sends each byte down one of three paths. Chain-4 packs consecutive bytes across the planes. Odd/even sends even and odd bytes to alternating planes. The planar path is the full pipeline: rotate, set/reset, logical function, bit mask and plane enable.

The register values that steer the paths are plain inputs, and so is the 32-bit latch loaded by the read side. These inputs must be held steady while `busy` is high. A request carries an aperture address, a size code and up to eight data bytes. The block breaks it into single-byte steps. Each step that changes memory reads the target word in one cycle and writes the merged word back in the next.

Top module: `vga_plane_writer`

## Requirements
- R1: Aperture decode by `cfg_map_sel`:
  - 0: the whole 17-bit address is the offset.
  - 1: only addresses below 0x10000 hit, and the offset is the address.
  - 2: the offset is the address minus 0x10000 and must be below 0x8000.
  - 3: the offset is the address minus 0x18000 and must be below 0x8000.
  - A byte that misses makes no memory access.
- R2: With `cfg_chain4` high, the byte goes to plane offset[1:0] of word offset>>2. It is written only if that plane's `cfg_map_mask` bit is set, and no other plane changes.
- R3: With `cfg_chain4` low and `cfg_odd_even` high, the plane is {`cfg_oe_plane_hi`, offset[0]} and the word is offset>>1. The write is gated by that plane's map mask bit.
- R4: Planar write mode 0 uses the CPU byte rotated right by `cfg_rotate`, copied to every plane. Planes whose `cfg_sr_enable` bit is set take 0xFF or 0x00 from their `cfg_set_reset` bit instead. The bit mask is `cfg_bit_mask`.
- R5: Planar write mode 1 writes the latch unchanged, with no function and no bit mask. The map mask still applies.
- R6: Planar write mode 2 expands CPU data bit p to a full byte for plane p. The bit mask is `cfg_bit_mask`.
- R7: Planar write mode 3 writes each plane's expanded `cfg_set_reset` bit. The bit mask is `cfg_bit_mask` ANDed with the rotated CPU byte.
- R8: In modes 0, 2 and 3, `cfg_func` combines the value with the latch: 0 passes it through, 1 is AND, 2 is OR, 3 is XOR.
- R9: In modes 0, 2 and 3, set bit-mask bits take the computed value in every plane. Clear bits take the latch.
- R10: Only planes enabled in `cfg_map_mask` are written, and the other planes keep their memory contents. A step that would enable no plane makes no memory access.
- R11: `req_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Bytes go to ascending addresses (modulo 2^17), least significant data byte first.
- R12: A memory access is `mem_rd` in one cycle, then `mem_wr` to the same address in the next. Read data is expected one cycle after `mem_rd`. `done` pulses for one cycle, while `busy` falls, a cycle after the last step. A one-byte planar write completes two cycles after acceptance, and a one-byte miss completes in one. After reset the block is idle with no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request, accepted when not busy |
| req_addr | input | 17 | Aperture byte address |
| req_size | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| req_data | input | 64 | Data bytes, low byte first |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_chain4 | input | 1 | Chain-4 addressing |
| cfg_odd_even | input | 1 | Odd/even addressing |
| cfg_oe_plane_hi | input | 1 | Upper plane bit for odd/even |
| cfg_map_sel | input | 2 | Aperture window select |
| cfg_map_mask | input | 4 | Plane write enables |
| cfg_write_mode | input | 2 | Planar write mode 0..3 |
| cfg_rotate | input | 3 | Rotate-right count |
| cfg_func | input | 2 | Latch function |
| cfg_set_reset | input | 4 | Per-plane set/reset value |
| cfg_sr_enable | input | 4 | Per-plane set/reset enable |
| cfg_bit_mask | input | 8 | Bit mask |
| latch | input | 32 | Latch from the read side |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |

## Verification
Directed writes use hand-picked bytes in each planar write mode:
- A rotate count of one with a single set/reset plane separates rotated CPU data from set/reset data.
- A partial bit mask over a patterned latch separates value bits from latch bits.
- An XOR function shows the latch is combined before the mask is applied.

Chain-4 and odd/even writes land in known lanes. Writes are also aimed at disabled planes and outside the selected window, which must cause no access. Randomised configurations, latch values, sizes and addresses clustered at window edges and the 17-bit wrap are then compared word by word against a reference memory image, together with the read count per request.

// File: rtl/vgaw_pkg.sv
`timescale 1ns/1ps
package vgaw_pkg;
   localparam int PLANES = 4;
   localparam int LANE_W = 8;
   localparam int WORD_W = PLANES * LANE_W;

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_MERGE} wr_state_e;
   typedef enum logic [1:0] {WM_ROTATE = 2'd0, WM_LATCH = 2'd1, WM_SPREAD = 2'd2, WM_MASKED = 2'd3} wmode_e;
   typedef enum logic [1:0] {FN_PASS = 2'd0, FN_AND = 2'd1, FN_OR = 2'd2, FN_XOR = 2'd3} func_e;

   function automatic logic [WORD_W-1:0] lanes_to_bits(input logic [PLANES-1:0] sel);
      logic [WORD_W-1:0] r;
      for (int p = 0; p < PLANES; p++) r[p*LANE_W +: LANE_W] = {LANE_W{sel[p]}};
      return r;
   endfunction

   function automatic logic [LANE_W-1:0] rot_right(input logic [LANE_W-1:0] d, input logic [2:0] n);
      logic [2*LANE_W-1:0] dbl;
      dbl = {d, d} >> n;
      return dbl[LANE_W-1:0];
   endfunction
endpackage

// File: rtl/vgaw_window.sv
`timescale 1ns/1ps
module vgaw_window #(
   parameter int WIN_AW = 17
) (
   input  logic [WIN_AW-1:0] addr,
   input  logic [1:0]        map_sel,
   output logic              hit,
   output logic [WIN_AW-1:0] offset
);
   localparam logic [WIN_AW-1:0] HALF  = WIN_AW'(1) << (WIN_AW - 1);
   localparam logic [WIN_AW-1:0] QTR   = WIN_AW'(1) << (WIN_AW - 2);
   localparam logic [WIN_AW-1:0] UPPER = HALF + QTR;

   if (WIN_AW < 4) begin : g_bad_aw
      $error("vgaw_window: WIN_AW too small");
   end

   always_comb begin
      unique case (map_sel)
         2'd0: begin offset = addr;         hit = 1'b1; end
         2'd1: begin offset = addr;         hit = ~addr[WIN_AW-1]; end
         2'd2: begin offset = addr - HALF;  hit = (offset < QTR); end
         default: begin offset = addr - UPPER; hit = (offset < QTR); end
      endcase
   end
endmodule

// File: rtl/vgaw_route.sv
`timescale 1ns/1ps
module vgaw_route #(
   parameter int WIN_AW = 17,
   parameter int MEM_AW = 16
) (
   input  logic [WIN_AW-1:0]          offset,
   input  logic                       chain4,
   input  logic                       odd_even,
   input  logic                       oe_hi,
   input  logic [vgaw_pkg::PLANES-1:0] map_mask,
   output logic [MEM_AW-1:0]          word_addr,
   output logic [vgaw_pkg::PLANES-1:0] lane_mask,
   output logic                       planar
);
   import vgaw_pkg::*;

   logic [1:0]        lane;
   logic [PLANES-1:0] lane_hot;

   always_comb begin
      planar = 1'b0;
      if (chain4) begin
         lane      = offset[1:0];
         word_addr = MEM_AW'(offset >> 2);
      end else if (odd_even) begin
         lane      = {oe_hi, offset[0]};
         word_addr = MEM_AW'(offset >> 1);
      end else begin
         lane      = 2'd0;
         word_addr = MEM_AW'(offset);
         planar    = 1'b1;
      end
   end

   for (genvar gp = 0; gp < PLANES; gp++) begin : g_lane
      assign lane_hot[gp]  = (lane == gp[1:0]);
      assign lane_mask[gp] = map_mask[gp] & (planar | lane_hot[gp]);
   end
endmodule

// File: rtl/vgaw_alu.sv
`timescale 1ns/1ps
module vgaw_alu (
   input  logic [vgaw_pkg::LANE_W-1:0] cpu_byte,
   input  logic [1:0]                  write_mode,
   input  logic [2:0]                  rotate,
   input  logic [1:0]                  func,
   input  logic [vgaw_pkg::PLANES-1:0] set_reset,
   input  logic [vgaw_pkg::PLANES-1:0] sr_enable,
   input  logic [vgaw_pkg::LANE_W-1:0] bit_mask,
   input  logic [vgaw_pkg::WORD_W-1:0] latch,
   output logic [vgaw_pkg::WORD_W-1:0] value
);
   import vgaw_pkg::*;

   wmode_e            wm;
   func_e             fn;
   logic [LANE_W-1:0] rotd;

   assign wm   = wmode_e'(write_mode);
   assign fn   = func_e'(func);
   assign rotd = rot_right(cpu_byte, rotate);

   for (genvar gp = 0; gp < PLANES; gp++) begin : g_plane
      logic [LANE_W-1:0] lb, src, opd, msk;
      assign lb = latch[gp*LANE_W +: LANE_W];

      always_comb begin
         msk = bit_mask;
         unique case (wm)
            WM_ROTATE: src = sr_enable[gp] ? {LANE_W{set_reset[gp]}} : rotd;
            WM_LATCH:  src = lb;
            WM_SPREAD: src = {LANE_W{cpu_byte[gp]}};
            default: begin
               src = {LANE_W{set_reset[gp]}};
               msk = bit_mask & rotd;
            end
         endcase
         unique case (fn)
            FN_PASS: opd = src;
            FN_AND:  opd = src & lb;
            FN_OR:   opd = src | lb;
            default: opd = src ^ lb;
         endcase
      end

      assign value[gp*LANE_W +: LANE_W] = (wm == WM_LATCH) ? lb : ((opd & msk) | (lb & ~msk));
   end
endmodule

// File: rtl/vga_plane_writer.sv
`timescale 1ns/1ps
module vga_plane_writer #(
   parameter int WIN_AW     = 17,
   parameter int MEM_AW     = 16,
   parameter int DATA_BYTES = 8,
   localparam int DATA_W = DATA_BYTES * 8,
   localparam int CNT_W  = $clog2(DATA_BYTES) + 1,
   localparam int SIZE_W = $clog2(CNT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WIN_AW-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   input  logic              cfg_chain4,
   input  logic              cfg_odd_even,
   input  logic              cfg_oe_plane_hi,
   input  logic [1:0]        cfg_map_sel,
   input  logic [3:0]        cfg_map_mask,
   input  logic [1:0]        cfg_write_mode,
   input  logic [2:0]        cfg_rotate,
   input  logic [1:0]        cfg_func,
   input  logic [3:0]        cfg_set_reset,
   input  logic [3:0]        cfg_sr_enable,
   input  logic [7:0]        cfg_bit_mask,
   input  logic [31:0]       latch,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata
);
   import vgaw_pkg::*;

   if ((DATA_BYTES < 2) || ((DATA_BYTES & (DATA_BYTES - 1)) != 0)) begin : g_bad_bytes
      $error("vga_plane_writer: DATA_BYTES must be a power of two, at least 2");
   end
   if (MEM_AW < 2) begin : g_bad_mem
      $error("vga_plane_writer: MEM_AW too small");
   end

   wr_state_e         state;
   logic [WIN_AW-1:0] cur_addr;
   logic [CNT_W-1:0]  left;
   logic [DATA_W-1:0] shreg;
   logic              done_q;

   logic              hit, planar, step;
   logic [WIN_AW-1:0] offset;
   logic [MEM_AW-1:0] word_addr;
   logic [PLANES-1:0] lane_mask, eff_mask;
   logic [WORD_W-1:0] alu_val, val, wmask;
   logic [LANE_W-1:0] cur_byte;

   assign cur_byte = shreg[LANE_W-1:0];

   vgaw_window #(.WIN_AW(WIN_AW)) u_window (
      .addr(cur_addr), .map_sel(cfg_map_sel), .hit(hit), .offset(offset)
   );

   vgaw_route #(.WIN_AW(WIN_AW), .MEM_AW(MEM_AW)) u_route (
      .offset(offset), .chain4(cfg_chain4), .odd_even(cfg_odd_even),
      .oe_hi(cfg_oe_plane_hi), .map_mask(cfg_map_mask),
      .word_addr(word_addr), .lane_mask(lane_mask), .planar(planar)
   );

   vgaw_alu u_alu (
      .cpu_byte(cur_byte), .write_mode(cfg_write_mode), .rotate(cfg_rotate),
      .func(cfg_func), .set_reset(cfg_set_reset), .sr_enable(cfg_sr_enable),
      .bit_mask(cfg_bit_mask), .latch(latch), .value(alu_val)
   );

   assign eff_mask  = hit ? lane_mask : '0;
   assign wmask     = lanes_to_bits(eff_mask);
   assign val       = planar ? alu_val : {PLANES{cur_byte}};
   assign mem_rd    = (state == ST_ISSUE) && (|eff_mask);
   assign mem_wr    = (state == ST_MERGE);
   assign mem_addr  = word_addr;
   assign mem_wdata = (mem_rdata & ~wmask) | (val & wmask);
   assign step      = ((state == ST_ISSUE) && !(|eff_mask)) || (state == ST_MERGE);
   assign busy      = (state != ST_IDLE);
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_addr <= '0;
         left     <= '0;
         shreg    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state == ST_IDLE) begin
            if (req_valid) begin
               cur_addr <= req_addr;
               left     <= CNT_W'(1) << req_size;
               shreg    <= req_data;
               state    <= ST_ISSUE;
            end
         end else if (step) begin
            if (left == CNT_W'(1)) begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end else begin
               cur_addr <= cur_addr + WIN_AW'(1);
               left     <= left - CNT_W'(1);
               shreg    <= shreg >> LANE_W;
               state    <= ST_ISSUE;
            end
         end else begin
            state <= ST_MERGE;
         end
      end
   end
endmodule

// File: rtl/vga_plane_writer_chk.sv
`timescale 1ns/1ps
module vga_plane_writer_chk #(
   parameter int MEM_AW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic [31:0]       mem_rdata,
   input logic              cfg_chain4,
   input logic              cfg_odd_even,
   input logic [1:0]        cfg_write_mode,
   input logic [3:0]        cfg_map_mask,
   input logic [31:0]       latch
);
   import vgaw_pkg::*;

   logic [PLANES-1:0] lane_diff;
   logic [WORD_W-1:0] map_bits;
   assign map_bits = lanes_to_bits(cfg_map_mask);

   for (genvar gp = 0; gp < PLANES; gp++) begin : g_diff
      assign lane_diff[gp] = |(mem_wdata[gp*LANE_W +: LANE_W] ^ mem_rdata[gp*LANE_W +: LANE_W]);
   end

   assert_rd_then_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (mem_wr && (mem_addr == $past(mem_addr))));
   assert_no_dual_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   assert_wr_needs_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));
   assert_done_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_keep_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (((mem_wdata ^ mem_rdata) & ~map_bits) == '0));
   assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && cfg_chain4) |-> $onehot0(lane_diff));
   assert_latch_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !cfg_chain4 && !cfg_odd_even && cfg_write_mode == 2'd1)
         |-> (((mem_wdata ^ latch) & map_bits) == '0));
endmodule

bind vga_plane_writer vga_plane_writer_chk #(.MEM_AW(MEM_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_rdata(mem_rdata), .cfg_chain4(cfg_chain4), .cfg_odd_even(cfg_odd_even),
   .cfg_write_mode(cfg_write_mode), .cfg_map_mask(cfg_map_mask), .latch(latch)
);

// File: tb/vga_plane_writer_bench.sv
`timescale 1ns/1ps
module vga_plane_writer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [16:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_data = '0;
   logic        busy, done;
   logic        c4 = 0, oe = 0, oehi = 0;
   logic [1:0]  msel = 0, wmode = 0, fnc = 0;
   logic [3:0]  mmask = 4'hF, srv = 0, sren = 0;
   logic [2:0]  rot = 0;
   logic [7:0]  bmask = 8'hFF;
   logic [31:0] lat = 0;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata = '0;

   int total = 0, bad = 0, rd_cnt = 0, exp_rd = 0;
   logic [31:0] dmem [int];
   logic [31:0] rmem [int];

   always #4 clk = ~clk;

   vga_plane_writer u_vga_plane_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_data(req_data), .busy(busy), .done(done),
      .cfg_chain4(c4), .cfg_odd_even(oe), .cfg_oe_plane_hi(oehi),
      .cfg_map_sel(msel), .cfg_map_mask(mmask), .cfg_write_mode(wmode),
      .cfg_rotate(rot), .cfg_func(fnc), .cfg_set_reset(srv), .cfg_sr_enable(sren),
      .cfg_bit_mask(bmask), .latch(lat), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_rd) begin
         rd_cnt++;
         mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 32'h0;
      end
      if (mem_wr) dmem[int'(mem_addr)] = mem_wdata;
   end

   function automatic logic [31:0] dget(int k);
      return dmem.exists(k) ? dmem[k] : 32'h0;
   endfunction
   function automatic logic [31:0] rget(int k);
      return rmem.exists(k) ? rmem[k] : 32'h0;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // Reference for one byte, written from the requirement list.
   function automatic void ref_byte(logic [16:0] a, logic [7:0] d);
      logic [16:0] off;
      bit          hit;
      int          w, ln;
      logic [31:0] word;
      logic [15:0] dbl;
      logic [7:0]  rb, lb, v, m, o;
      case (msel)
         2'd0: begin off = a; hit = 1; end
         2'd1: begin off = a; hit = (a < 17'h10000); end
         2'd2: begin off = a - 17'h10000; hit = (off < 17'h08000); end
         default: begin off = a - 17'h18000; hit = (off < 17'h08000); end
      endcase
      if (!hit) return;
      if (c4 || oe) begin
         if (c4) begin ln = int'(off[1:0]); w = int'(off[17:2] & 16'hFFFF); end
         else begin ln = int'({oehi, off[0]}); w = int'((off >> 1) & 17'hFFFF); end
         if (!mmask[ln]) return;
         word = rget(w);
         word[ln*8 +: 8] = d;
         rmem[w] = word;
         exp_rd++;
         return;
      end
      if (mmask == 4'h0) return;
      w = int'(off[15:0]);
      word = rget(w);
      dbl = {d, d} >> rot;
      rb = dbl[7:0];
      for (int p = 0; p < 4; p++) begin
         lb = lat[p*8 +: 8];
         m = bmask;
         case (wmode)
            2'd0: v = sren[p] ? {8{srv[p]}} : rb;
            2'd2: v = {8{d[p]}};
            2'd3: begin v = {8{srv[p]}}; m = bmask & rb; end
            default: v = lb;
         endcase
         case (fnc)
            2'd1: v = v & lb;
            2'd2: v = v | lb;
            2'd3: v = v ^ lb;
            default: ;
         endcase
         o = (wmode == 2'd1) ? lb : ((v & m) | (lb & ~m));
         if (mmask[p]) word[p*8 +: 8] = o;
      end
      rmem[w] = word;
      exp_rd++;
   endfunction

   task automatic run_txn(string tag, logic [16:0] a, logic [1:0] sz, logic [63:0] d, int lat_exp);
      int n = 0, mism = 0, fk = 0;
      int nb = 1 << sz;
      exp_rd = 0;
      for (int i = 0; i < nb; i++) ref_byte(a + 17'(i), d[i*8 +: 8]);
      @(negedge clk);
      rd_cnt = 0;
      req_valid = 1; req_addr = a; req_size = sz; req_data = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      while (!done && n < 100) begin
         @(posedge clk); n++;
         @(negedge clk);
      end
      if (lat_exp >= 0) chk(n == lat_exp, tag, "latency", 64'(n), 64'(lat_exp));
      chk(rd_cnt == exp_rd, tag, "read count", 64'(rd_cnt), 64'(exp_rd));
      foreach (dmem[k]) if (dmem[k] !== rget(k)) begin mism++; fk = k; end
      foreach (rmem[k]) if (rmem[k] !== dget(k)) begin mism++; fk = k; end
      chk(mism == 0, tag, $sformatf("memory image word %0h", fk), 64'(dget(fk)), 64'(rget(fk)));
   endtask

   task automatic planar_cfg(logic [1:0] wm, logic [2:0] r, logic [1:0] f, logic [3:0] sv,
                             logic [3:0] se, logic [7:0] bm, logic [3:0] mm, logic [31:0] l);
      c4 = 0; oe = 0; msel = 0; wmode = wm; rot = r; fnc = f; srv = sv; sren = se;
      bmask = bm; mmask = mm; lat = l;
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [16:0] bases [6] = '{17'h00000, 17'h0FFF0, 17'h10000, 17'h17FF8, 17'h18000, 17'h1FFF8};
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !done && !mem_rd && !mem_wr, "R12", "reset idle", 64'({busy, done, mem_rd, mem_wr}), 64'h0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !mem_rd && !mem_wr, "R12", "idle after reset", 64'({busy, mem_rd, mem_wr}), 64'h0);

      // R4: rotate 1 of 0x03 -> 0x81, plane 0 forced to 0xFF by set/reset
      planar_cfg(2'd0, 3'd1, 2'd0, 4'h1, 4'h1, 8'hFF, 4'hF, 32'h0);
      run_txn("R4", 17'h00010, 2'd0, 64'h03, 2);
      chk(dget(16'h0010) == 32'h818181FF, "R4", "mode0 word", 64'(dget(16'h0010)), 64'h818181FF);
      // R7: mode3 mask 0x3C & 0x0F = 0x0C, set/reset 0101 over latch AA
      planar_cfg(2'd3, 3'd0, 2'd0, 4'h5, 4'h0, 8'h3C, 4'hF, 32'hAAAAAAAA);
      run_txn("R7", 17'h00030, 2'd0, 64'h0F, 2);
      chk(dget(16'h0030) == 32'hA2AEA2AE, "R7", "mode3 word", 64'(dget(16'h0030)), 64'hA2AEA2AE);
      // R8: mode2 data 0x05 XOR latch 0F0F0F0F
      planar_cfg(2'd2, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0F0F0F0F);
      run_txn("R8", 17'h00050, 2'd0, 64'h05, 2);
      chk(dget(16'h0050) == 32'h0FF00FF0, "R8", "xor word", 64'(dget(16'h0050)), 64'h0FF00FF0);
      // R9: mode2 all ones, bit mask 0x0F keeps latch high nibbles
      planar_cfg(2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'h0F, 4'hF, 32'h12345678);
      run_txn("R9", 17'h00060, 2'd0, 64'h0F, 2);
      chk(dget(16'h0060) == 32'h1F3F5F7F, "R9", "bit mask word", 64'(dget(16'h0060)), 64'h1F3F5F7F);
      // R5 and R10: latch copy only into planes 0 and 2
      planar_cfg(2'd1, 3'd0, 2'd3, 4'h0, 4'h0, 8'h00, 4'h5, 32'hDEADBEEF);
      run_txn("R5", 17'h00060, 2'd0, 64'h00, 2);
      chk(dget(16'h0060) == 32'h1FAD5FEF, "R10", "map mask merge", 64'(dget(16'h0060)), 64'h1FAD5FEF);
      // R6: data 0x09 -> planes 0 and 3 full
      planar_cfg(2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      run_txn("R6", 17'h00070, 2'd0, 64'h09, 2);
      chk(dget(16'h0070) == 32'hFF0000FF, "R6", "spread word", 64'(dget(16'h0070)), 64'hFF0000FF);
      // R10: no plane enabled -> no access
      planar_cfg(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'h0, 32'h0);
      run_txn("R10", 17'h00070, 2'd0, 64'h55, 1);
      // R2: chain-4 lane 2 of word 1, then a gated lane
      c4 = 1; mmask = 4'hF;
      run_txn("R2", 17'h00006, 2'd0, 64'h5A, 2);
      chk(dget(16'h0001) == 32'h005A0000, "R2", "chain4 word", 64'(dget(16'h0001)), 64'h005A0000);
      mmask = 4'hB;
      run_txn("R2", 17'h0000A, 2'd0, 64'h77, 1);
      chk(dget(16'h0002) == 32'h0, "R2", "gated lane untouched", 64'(dget(16'h0002)), 64'h0);
      // R3: odd/even, upper plane bit set, odd address -> plane 3 of word 0x20
      c4 = 0; oe = 1; oehi = 1; mmask = 4'hF;
      run_txn("R3", 17'h00041, 2'd0, 64'h3C, 2);
      chk(dget(16'h0020) == 32'h3C000000, "R3", "odd/even word", 64'(dget(16'h0020)), 64'h3C000000);
      // R1: window 1 misses upper half; window 2 offsets by 0x10000
      planar_cfg(2'd2, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      msel = 2'd1;
      run_txn("R1", 17'h10005, 2'd0, 64'h0F, 1);
      msel = 2'd2;
      run_txn("R1", 17'h10004, 2'd0, 64'h0F, 2);
      chk(dget(16'h0004) == 32'hFFFFFFFF, "R1", "window 2 offset", 64'(dget(16'h0004)), 64'hFFFFFFFF);
      // R11: eight chain-4 bytes across the 17-bit wrap
      msel = 2'd0; c4 = 1;
      run_txn("R11", 17'h1FFFE, 2'd3, 64'h8877665544332211, 16);

      for (int t = 0; t < 300; t++) begin
         string tag;
         int sel = $urandom_range(0, 5);
         c4 = ($urandom_range(0, 3) == 0);
         oe = ($urandom_range(0, 2) == 0);
         oehi = 1'($urandom); msel = 2'($urandom); wmode = 2'($urandom);
         rot = 3'($urandom); fnc = 2'($urandom); srv = 4'($urandom); sren = 4'($urandom);
         bmask = 8'($urandom); mmask = 4'($urandom); lat = $urandom;
         if (c4) tag = "R2";
         else if (oe) tag = "R3";
         else case (wmode)
            2'd0: tag = "R4";
            2'd1: tag = "R5";
            2'd2: tag = "R6";
            default: tag = "R7";
         endcase
         run_txn(tag, bases[sel] + 17'($urandom_range(0, 15)), 2'($urandom),
                 {$urandom, $urandom}, -1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule